// File: doc/BRIEF.md
# Two-Ratio Fractional Tick Generator

This block produces a one-cycle tick enable, at a rate that is not an integer fraction of its clock, from a fast reference clock. It alternates between two integer divisors. The first divisor is used for a programmed number of consecutive output periods, then the second divisor for another programmed number, and the pattern repeats. The long-run rate is the clock rate divided by the weighted mean of the two divisors. With a 24 MHz reference, divisors of 733 and 732 used for 2 and 3 periods give a mean of 732.4 clocks, which is close to 32768 Hz.

The derived path runs only when both the reference gate enable and the output enable are high. A source select picks either the derived tick or a native slow tick that arrives already synchronous to the clock. The chosen tick leaves the block through one register. Divisor and repeat-count changes are held back until a full burst sequence ends, so the mean rate is never disturbed in the middle of a pattern. While the derived path is stopped, the block takes the programmed values at once.

Top module: `frac_tick_gen`

## Requirements
- R1: While reset is asserted and on the first cycles after it, `tick_out` is 0. The period and phase counters start from their initial state.
- R2: While the derived path runs, successive derived ticks are exactly D clock cycles apart, where D is the divisor of the current phase. The first tick after enabling comes D cycles after the enable rises.
- R3: The burst order is `rep_a` periods with divisor `div_a`, then `rep_b` periods with divisor `div_b`, repeating. With 733/732 and 2/3 the gaps are 733, 733, 732, 732, 732, 733, and so on.
- R4: A repeat count of 0 skips its phase, so every gap uses the other divisor.
- R5: When both repeat counts are 0, no derived tick is produced.
- R6: A change to `div_a`, `div_b`, `rep_a` or `rep_b` while the derived path runs takes effect only after the last period of the current sequence. While the path is stopped, the change is taken at once.
- R7: The derived path needs both `gate_en` and `out_en` high. If either is low, no derived tick occurs and the counters return to the start of a sequence.
- R8: `use_derived`=1 selects the derived tick and `use_derived`=0 selects `slow_tick`. The selected tick appears on `tick_out` one clock after it occurs, and the path that is not selected has no effect.
- R9: A divisor of 0 or 1 gives a gap of one cycle, so a tick occurs on every running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_en | input | 1 | Reference gate enable for the derived path |
| out_en | input | 1 | Output enable for the derived path |
| use_derived | input | 1 | Source select: 1 derived, 0 native |
| slow_tick | input | 1 | Native slow tick, one cycle wide, synchronous to clk |
| div_a | input | DIV_W | Divisor of the first phase |
| div_b | input | DIV_W | Divisor of the second phase |
| rep_a | input | REP_W | Period count of the first phase |
| rep_b | input | REP_W | Period count of the second phase |
| tick_out | output | 1 | Selected tick, registered |

## Verification
The hardest case to reach is a configuration change that arrives in the middle of a running sequence. To observe it, the rule that holds the new values back has to be seen at the exact period where the sequence wraps. The bench starts a short pattern from the stopped state, so the phase alignment is known. It changes the first divisor right after the first gap and then checks that the remaining gaps of that sequence keep the old value, and that the following sequence uses the new one. Skipped phases and divisors of 0 and 1 are reached by programming those values directly while the path is stopped.

// File: rtl/frac_tick_pkg.sv
package frac_tick_pkg;

  typedef enum logic {
    FD_PH_A = 1'b0,
    FD_PH_B = 1'b1
  } fd_phase_e;

  // True when a count of cnt has reached the last step of a span of lim.
  // Spans of 0 and 1 are both treated as a single step.
  function automatic logic fd_reached(input logic [31:0] cnt, input logic [31:0] lim);
    return (cnt + 32'd1) >= lim;
  endfunction

  // Phase with which a sequence starts: the first phase is skipped when its count is 0.
  function automatic fd_phase_e fd_start_phase(input logic [31:0] reps_first);
    return (reps_first == 32'd0) ? FD_PH_B : FD_PH_A;
  endfunction

endpackage

// File: rtl/frac_tick_cfg_hold.sv
module frac_tick_cfg_hold #(
  parameter int DIV_W     = 12,
  parameter int REP_W     = 4,
  parameter int DEF_DIV_A = 733,
  parameter int DEF_DIV_B = 732,
  parameter int DEF_REP_A = 2,
  parameter int DEF_REP_B = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_a_in,
  input  logic [DIV_W-1:0] div_b_in,
  input  logic [REP_W-1:0] rep_a_in,
  input  logic [REP_W-1:0] rep_b_in,
  output logic [DIV_W-1:0] div_a_q,
  output logic [DIV_W-1:0] div_b_q,
  output logic [REP_W-1:0] rep_a_q,
  output logic [REP_W-1:0] rep_b_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_a_q <= DIV_W'(DEF_DIV_A);
      div_b_q <= DIV_W'(DEF_DIV_B);
      rep_a_q <= REP_W'(DEF_REP_A);
      rep_b_q <= REP_W'(DEF_REP_B);
    end else if (load) begin
      div_a_q <= div_a_in;
      div_b_q <= div_b_in;
      rep_a_q <= rep_a_in;
      rep_b_q <= rep_b_in;
    end
  end

endmodule

// File: rtl/frac_tick_period.sv
module frac_tick_period
  import frac_tick_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick,
  output logic [DIV_W-1:0] count
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  assign tick = active && fd_reached(32'(count), 32'(divisor));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (!active || tick) begin
      count <= '0;
    end else begin
      count <= count + ONE;
    end
  end

endmodule

// File: rtl/frac_tick_phase.sv
module frac_tick_phase
  import frac_tick_pkg::*;
#(
  parameter int REP_W     = 4,
  parameter int DEF_REP_A = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic [REP_W-1:0] lim_a,
  input  logic [REP_W-1:0] lim_b,
  input  logic [REP_W-1:0] next_lim_a,
  output fd_phase_e        phase,
  output logic [REP_W-1:0] reps,
  output logic             seq_end
);

  localparam logic [REP_W-1:0] ONE = REP_W'(1);

  logic last_a;
  logic last_b;

  assign last_a  = fd_reached(32'(reps), 32'(lim_a));
  assign last_b  = fd_reached(32'(reps), 32'(lim_b));
  assign seq_end = active && tick &&
                   ((phase == FD_PH_B) ? last_b : (last_a && (lim_b == '0)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= fd_start_phase(32'(DEF_REP_A));
      reps  <= '0;
    end else if (!active || seq_end) begin
      phase <= fd_start_phase(32'(next_lim_a));
      reps  <= '0;
    end else if (tick) begin
      if (phase == FD_PH_A && last_a) begin
        phase <= FD_PH_B;
        reps  <= '0;
      end else begin
        reps <= reps + ONE;
      end
    end
  end

endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
  import frac_tick_pkg::*;
#(
  parameter int DIV_W     = 12,
  parameter int REP_W     = 4,
  parameter int DEF_DIV_A = 733,
  parameter int DEF_DIV_B = 732,
  parameter int DEF_REP_A = 2,
  parameter int DEF_REP_B = 3,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_en,
  input  logic             out_en,
  input  logic             use_derived,
  input  logic             slow_tick,
  input  logic [DIV_W-1:0] div_a,
  input  logic [DIV_W-1:0] div_b,
  input  logic [REP_W-1:0] rep_a,
  input  logic [REP_W-1:0] rep_b,
  output logic             tick_out
);

  logic [DIV_W-1:0] div_a_q;
  logic [DIV_W-1:0] div_b_q;
  logic [REP_W-1:0] rep_a_q;
  logic [REP_W-1:0] rep_b_q;
  logic             run_req;
  logic             has_reps;
  logic             active;
  logic             cfg_load;
  logic             seq_end;
  logic             div_tick;
  logic [DIV_W-1:0] pcnt;
  logic [DIV_W-1:0] divisor;
  logic [REP_W-1:0] reps;
  fd_phase_e        phase;
  logic             sel_tick;

  assign run_req  = gate_en && out_en;
  assign has_reps = (rep_a_q != '0) || (rep_b_q != '0);
  assign active   = run_req && has_reps;
  assign cfg_load = !active || seq_end;
  assign divisor  = (phase == FD_PH_B) ? div_b_q : div_a_q;
  assign sel_tick = use_derived ? div_tick : slow_tick;

  frac_tick_cfg_hold #(
    .DIV_W(DIV_W), .REP_W(REP_W),
    .DEF_DIV_A(DEF_DIV_A), .DEF_DIV_B(DEF_DIV_B),
    .DEF_REP_A(DEF_REP_A), .DEF_REP_B(DEF_REP_B)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .div_a_in(div_a), .div_b_in(div_b), .rep_a_in(rep_a), .rep_b_in(rep_b),
    .div_a_q(div_a_q), .div_b_q(div_b_q), .rep_a_q(rep_a_q), .rep_b_q(rep_b_q)
  );

  frac_tick_period #(.DIV_W(DIV_W)) u_period (
    .clk(clk), .rst_n(rst_n), .active(active), .divisor(divisor),
    .tick(div_tick), .count(pcnt)
  );

  frac_tick_phase #(.REP_W(REP_W), .DEF_REP_A(DEF_REP_A)) u_phase (
    .clk(clk), .rst_n(rst_n), .active(active), .tick(div_tick),
    .lim_a(rep_a_q), .lim_b(rep_b_q), .next_lim_a(rep_a),
    .phase(phase), .reps(reps), .seq_end(seq_end)
  );

  generate
    if (REG_OUT) begin : g_reg_out
      logic tick_q;
      always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= sel_tick;
      end
      assign tick_out = tick_q;
    end else begin : g_comb_out
      assign tick_out = sel_tick && rst_n;
    end
  endgenerate

endmodule

// File: rtl/frac_tick_gen_chk.sv
module frac_tick_gen_chk #(
  parameter int DIV_W   = 12,
  parameter int REP_W   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_en,
  input logic             out_en,
  input logic             use_derived,
  input logic             slow_tick,
  input logic             tick_out,
  input logic             active,
  input logic             div_tick,
  input logic             seq_end,
  input logic             cfg_load,
  input logic [DIV_W-1:0] pcnt,
  input logic [DIV_W-1:0] divisor,
  input logic [DIV_W-1:0] div_a_q,
  input logic [DIV_W-1:0] div_b_q,
  input logic [REP_W-1:0] rep_a_q,
  input logic [REP_W-1:0] rep_b_q
);

  localparam int DW1 = DIV_W + 1;

  assert_gated_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_en && out_en) |-> !div_tick);

  assert_no_reps_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_a_q == '0 && rep_b_q == '0) |-> !div_tick);

  assert_seq_end_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end |-> div_tick);

  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> ($stable(div_a_q) && $stable(div_b_q) && $stable(rep_a_q) && $stable(rep_b_q)));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !div_tick) |-> (DW1'(pcnt) + DW1'(1) < DW1'(divisor)));

  assert_native_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT && !use_derived && !slow_tick) |=> !tick_out);

endmodule

bind frac_tick_gen frac_tick_gen_chk #(.DIV_W(DIV_W), .REP_W(REP_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .out_en(out_en),
  .use_derived(use_derived), .slow_tick(slow_tick), .tick_out(tick_out),
  .active(active), .div_tick(div_tick), .seq_end(seq_end), .cfg_load(cfg_load),
  .pcnt(pcnt), .divisor(divisor), .div_a_q(div_a_q), .div_b_q(div_b_q),
  .rep_a_q(rep_a_q), .rep_b_q(rep_b_q)
);

// File: tb/frac_tick_gen_test.sv
module frac_tick_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 12;
  localparam int REP_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_en = 1'b0;
  logic out_en = 1'b0;
  logic use_derived = 1'b1;
  logic slow_tick = 1'b0;
  logic [DIV_W-1:0] div_a = '0;
  logic [DIV_W-1:0] div_b = '0;
  logic [REP_W-1:0] rep_a = '0;
  logic [REP_W-1:0] rep_b = '0;
  logic tick_out;

  int errors = 0;
  int checks = 0;
  int gaps[16];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .out_en(out_en),
    .use_derived(use_derived), .slow_tick(slow_tick),
    .div_a(div_a), .div_b(div_b), .rep_a(rep_a), .rep_b(rep_b),
    .tick_out(tick_out)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Stop the path, program it, and restart it at a negedge (stopped-state load).
  task automatic start_cfg(input int a, input int b, input int ma, input int mb);
    @(negedge clk);
    gate_en = 1'b0;
    div_a = DIV_W'(a); div_b = DIV_W'(b);
    rep_a = REP_W'(ma); rep_b = REP_W'(mb);
    @(negedge clk);
    gate_en = 1'b1; out_en = 1'b1; use_derived = 1'b1;
  endtask

  // Record n gaps in cycles; after gap index chg_at, set div_a to chg_val.
  task automatic collect(input int n, input int chg_at, input int chg_val);
    int cnt = 0;
    int idx = 0;
    while (idx < n) begin
      @(negedge clk);
      cnt++;
      if (tick_out) begin
        gaps[idx] = cnt;
        if (idx == chg_at) div_a = DIV_W'(chg_val);
        idx++;
        cnt = 0;
      end else if (cnt > 5000) begin
        gaps[idx] = -1;
        idx++;
        cnt = 0;
      end
    end
  endtask

  task automatic count_quiet(input string req, input int cycles);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tick_out) seen++;
    end
    check(req, seen, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 during reset", int'(tick_out), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", int'(tick_out), 0);
  endtask

  task automatic t_basic_pattern();
    int exp[10] = '{5, 5, 4, 4, 4, 5, 5, 4, 4, 4};
    start_cfg(5, 4, 2, 3);
    collect(10, -1, 0);
    for (int i = 0; i < 10; i++) check("R2 R3 small burst gap", gaps[i], exp[i]);
  endtask

  task automatic t_nominal();
    int exp[6] = '{733, 733, 732, 732, 732, 733};
    int total = 0;
    start_cfg(733, 732, 2, 3);
    collect(6, -1, 0);
    for (int i = 0; i < 6; i++) check("R3 nominal gap", gaps[i], exp[i]);
    for (int i = 0; i < 5; i++) total += gaps[i];
    check("R3 sequence length", total, 733 * 2 + 732 * 3);
  endtask

  task automatic t_skip_phase();
    start_cfg(5, 3, 0, 2);
    collect(4, -1, 0);
    for (int i = 0; i < 4; i++) check("R4 first phase skipped", gaps[i], 3);
    start_cfg(6, 3, 2, 0);
    collect(4, -1, 0);
    for (int i = 0; i < 4; i++) check("R4 second phase skipped", gaps[i], 6);
  endtask

  task automatic t_no_reps();
    start_cfg(3, 3, 0, 0);
    count_quiet("R5 both counts zero", 100);
  endtask

  task automatic t_mid_change();
    int exp[10] = '{5, 5, 4, 4, 4, 7, 7, 4, 4, 4};
    start_cfg(5, 4, 2, 3);
    collect(10, 0, 7);
    for (int i = 0; i < 10; i++) check("R6 change deferred to sequence end", gaps[i], exp[i]);
  endtask

  task automatic t_enables();
    start_cfg(3, 3, 1, 1);
    @(negedge clk);
    out_en = 1'b0;
    count_quiet("R7 out_en low", 50);
    out_en = 1'b1; gate_en = 1'b0;
    count_quiet("R7 gate_en low", 50);
    gate_en = 1'b1;
    collect(1, -1, 0);
    check("R7 restart from sequence start", gaps[0], 3);
  endtask

  task automatic t_source_select();
    start_cfg(3, 3, 1, 1);
    @(negedge clk);
    use_derived = 1'b0;
    @(negedge clk);
    count_quiet("R8 derived ignored when native selected", 30);
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
    check("R8 native tick passed", int'(tick_out), 1);
    @(negedge clk);
    check("R8 native tick one cycle", int'(tick_out), 0);
    gate_en = 1'b0;
    use_derived = 1'b1;
    slow_tick = 1'b1;
    @(negedge clk);
    @(negedge clk);
    slow_tick = 1'b0;
    check("R8 native ignored when derived selected", int'(tick_out), 0);
  endtask

  task automatic t_unit_divisor();
    start_cfg(1, 0, 1, 1);
    collect(4, -1, 0);
    for (int i = 0; i < 4; i++) check("R9 divisor 1 and 0 tick every cycle", gaps[i], 1);
  endtask

  initial begin
    t_reset();
    t_basic_pattern();
    t_nominal();
    t_skip_phase();
    t_no_reps();
    t_mid_change();
    t_enables();
    t_source_select();
    t_unit_divisor();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule